// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the horizontal and vertical raster timing for a text display of 40 character cells, each 8 pixels wide, advancing one pixel per clock. Each scan line is divided into segments in this order: a fixed 8-clock lead-in, a programmable left margin, 320 active pixels, a right margin of the same width, and a blanking tail. Each frame is a programmable number of scan lines. A horizontal sync pulse is placed anywhere in the line at 2-pixel granularity. Its polarity follows from which of the two edge positions comes first.

The configuration fields are plain inputs. The block copies them into working registers at fixed points in the raster, so software can change them at any time without tearing a line or a frame. An optional composite mode merges vertical sync into the sync pin. An optional interlace mode shifts every other field by half a line and reports which field is being scanned. Every output is registered, and all outputs are aligned to the same pixel position.

Top module: `crt_raster_gen`

## Requirements
- R1: `pix_x` counts 0, 1, …, (len+1)×8−1 and then returns to 0, where len is the 6-bit `cfg_line_len` value held for that line.
- R2: With W=(margin+1)×8, where margin is the 3-bit `cfg_margin` value, `active` is 1 exactly for `pix_x` in [8+W, 8+W+320) and `margin` is 1 exactly for `pix_x` in [8, 8+W) or [8+W+320, 8+2W+320). If the line is too short for a segment, that segment is cut off at the end of the line.
- R3: With rise=(su+1)×2 and fall=(sd+1)×2, taken from the 8-bit `cfg_sync_rise`/`cfg_sync_fall`: if su<sd, `hsync` is 1 exactly for `pix_x` in [rise, fall); if su>sd, `hsync` is 0 exactly for `pix_x` in [fall, rise) and 1 elsewhere. When `cfg_composite`=0, `sync_out` equals `hsync`.
- R4: `line_cnt` advances by one each time `pix_x` returns to 0, and it runs from 0 up to f+1 before returning to 0, so a frame has f+2 lines, where f is the 9-bit `cfg_frame_lines` value.
- R5: On an even field (`field_odd`=0), `vsync` is 1 exactly on lines 0, 1 and 2.
- R6: When `cfg_composite`=1, the active-level sync (hsync when su<sd, its inverse otherwise) is XORed with `vsync`. `sync_out` carries this XOR result, inverted again when su>sd.
- R7: When the interlace bit sampled at a frame start is 1, `field_odd` toggles at that frame start. Otherwise it is 0. On an odd field, `vsync` is 1 from the pixel at half the line length on line 0 up to, but not including, the same pixel on line 3.
- R8: While `rst` is high, every output is 0. After reset, the working values are len=0x3F, margin=3, su=0xE6, sd=0xDC and f=0x136, giving 512-clock lines, a sync low for `pix_x` in [442, 462), and 312 lines per frame.
- R9: Line length, margin, sync positions and the composite bit are sampled at each line start. The frame length and the interlace bit are sampled only at each frame start, so a change made in the middle of a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_len | input | 6 | Line length code; the line has (code+1)×8 clocks |
| cfg_margin | input | 3 | Margin code; each margin has (code+1)×8 clocks |
| cfg_sync_rise | input | 8 | Sync rising edge at (code+1)×2 |
| cfg_sync_fall | input | 8 | Sync falling edge at (code+1)×2 |
| cfg_frame_lines | input | 9 | Frame length code; the frame has code+2 lines |
| cfg_interlace | input | 1 | 1 selects interlaced scanning |
| cfg_composite | input | 1 | 1 puts composite sync on `sync_out` |
| pix_x | output | 9 | Pixel position in the line |
| line_cnt | output | 10 | Scan line within the frame |
| active | output | 1 | Active display area |
| margin | output | 1 | Left or right margin |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync, active high |
| sync_out | output | 1 | Horizontal or composite sync, per mode |
| field_odd | output | 1 | Field parity |

## Verification
The checker verifies on every cycle the properties that need no knowledge of the current settings: `pix_x` only increments or returns to zero; the line count changes only at a line start and then by one; active and margin are never both high and active never starts before the shortest lead-in plus margin; even-field vsync stays within the first three lines; field parity changes only at the frame origin; and reset clears the outputs. The exact segment boundaries, the sync edge positions and polarity, the composite XOR, the half-line offset of odd fields, and the timing of register updates depend on the programmed values. Only the bench can show these, by sweeping several configurations against a pixel-by-pixel arithmetic model.

// File: rtl/crt_raster_pkg.sv
package crt_raster_pkg;

  typedef enum logic [2:0] {
    SEG_LEAD   = 3'd0,
    SEG_LEFT   = 3'd1,
    SEG_ACTIVE = 3'd2,
    SEG_RIGHT  = 3'd3,
    SEG_TAIL   = 3'd4
  } seg_e;

  localparam int unsigned DEF_LINE_LEN = 63;
  localparam int unsigned DEF_MARGIN   = 3;
  localparam int unsigned DEF_RISE     = 230;
  localparam int unsigned DEF_FALL     = 220;
  localparam int unsigned DEF_FRAME    = 310;

endpackage

// File: rtl/crt_raster_hcount.sv
module crt_raster_hcount
  import crt_raster_pkg::*;
#(
  parameter int L_W       = 6,
  parameter int MG_W      = 3,
  parameter int SE_W      = 8,
  parameter int CHAR_PIX  = 8,
  parameter int ACT_CHARS = 40,
  parameter int PIX_W     = 9,
  parameter int RST_LEN   = 63,
  parameter int RST_MG    = 3,
  parameter int RST_RISE  = 230,
  parameter int RST_FALL  = 220
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [L_W-1:0]   cfg_len,
  input  logic [MG_W-1:0]  cfg_margin,
  input  logic [SE_W-1:0]  cfg_rise,
  input  logic [SE_W-1:0]  cfg_fall,
  input  logic             cfg_comp,
  output logic [PIX_W-1:0] hpos,
  output logic             line_end,
  output seg_e             seg,
  output logic             hs_level,
  output logic             hs_positive,
  output logic             second_half,
  output logic             comp_mode
);

  localparam int SH        = $clog2(CHAR_PIX);
  localparam int SPW       = SE_W + 2;
  localparam int CW        = ((PIX_W > SPW) ? PIX_W : SPW) + 2;
  localparam int ACT_PIX   = ACT_CHARS * CHAR_PIX;
  localparam int LEAD_PIX  = CHAR_PIX;

  logic [L_W-1:0]  len_q;
  logic [MG_W-1:0] mg_q;
  logic [SE_W-1:0] su_q;
  logic [SE_W-1:0] sd_q;
  logic            comp_q;

  logic [CW-1:0] hx, hlen, mwid, act_lo, act_hi, rgt_hi, rise_at, fall_at;

  always_comb begin
    hx      = CW'(hpos);
    hlen    = (CW'(len_q) + CW'(1)) << SH;
    mwid    = (CW'(mg_q) + CW'(1)) << SH;
    act_lo  = CW'(LEAD_PIX) + mwid;
    act_hi  = act_lo + CW'(ACT_PIX);
    rgt_hi  = act_hi + mwid;
    rise_at = (CW'(su_q) + CW'(1)) << 1;
    fall_at = (CW'(sd_q) + CW'(1)) << 1;
  end

  always_comb begin
    if (hx < CW'(LEAD_PIX))  seg = SEG_LEAD;
    else if (hx < act_lo)    seg = SEG_LEFT;
    else if (hx < act_hi)    seg = SEG_ACTIVE;
    else if (hx < rgt_hi)    seg = SEG_RIGHT;
    else                     seg = SEG_TAIL;
  end

  always_comb begin
    line_end    = (hx == hlen - CW'(1));
    hs_positive = (su_q < sd_q);
    if (hs_positive) hs_level = (hx >= rise_at) && (hx < fall_at);
    else             hs_level = !((hx >= fall_at) && (hx < rise_at));
    second_half = (hx >= (hlen >> 1));
    comp_mode   = comp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos   <= '0;
      len_q  <= L_W'(RST_LEN);
      mg_q   <= MG_W'(RST_MG);
      su_q   <= SE_W'(RST_RISE);
      sd_q   <= SE_W'(RST_FALL);
      comp_q <= 1'b0;
    end else if (line_end) begin
      hpos   <= '0;
      len_q  <= cfg_len;
      mg_q   <= cfg_margin;
      su_q   <= cfg_rise;
      sd_q   <= cfg_fall;
      comp_q <= cfg_comp;
    end else begin
      hpos   <= hpos + PIX_W'(1);
    end
  end

endmodule

// File: rtl/crt_raster_vcount.sv
module crt_raster_vcount #(
  parameter int F_W   = 9,
  parameter int LN_W  = 10,
  parameter int RST_F = 310
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  logic [F_W-1:0]  cfg_frame,
  input  logic            cfg_interlace,
  output logic [LN_W-1:0] vline,
  output logic            field_odd
);

  logic [F_W-1:0] f_q;
  logic           last_line;

  assign last_line = (vline == LN_W'(f_q) + LN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      vline     <= '0;
      f_q       <= F_W'(RST_F);
      field_odd <= 1'b0;
    end else if (line_end) begin
      if (last_line) begin
        vline     <= '0;
        f_q       <= cfg_frame;
        field_odd <= cfg_interlace ? ~field_odd : 1'b0;
      end else begin
        vline <= vline + LN_W'(1);
      end
    end
  end

endmodule

// File: rtl/crt_raster_sync.sv
module crt_raster_sync #(
  parameter int LN_W     = 10,
  parameter int VS_LINES = 3
) (
  input  logic [LN_W-1:0] vline,
  input  logic            field_odd,
  input  logic            second_half,
  input  logic            hs_level,
  input  logic            hs_positive,
  input  logic            comp_mode,
  output logic            vs_act,
  output logic            sync_pin
);

  localparam logic [LN_W-1:0] VSL = LN_W'(VS_LINES);

  logic even_vs, odd_vs, hs_act, cs_act;

  always_comb begin
    even_vs  = (vline < VSL);
    odd_vs   = ((vline == '0) && second_half) ||
               ((vline != '0) && (vline < VSL)) ||
               ((vline == VSL) && !second_half);
    vs_act   = field_odd ? odd_vs : even_vs;
    hs_act   = hs_positive ? hs_level : ~hs_level;
    cs_act   = hs_act ^ vs_act;
    if (comp_mode) sync_pin = hs_positive ? cs_act : ~cs_act;
    else           sync_pin = hs_level;
  end

endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
  import crt_raster_pkg::*;
#(
  parameter int L_W       = 6,
  parameter int MG_W      = 3,
  parameter int SE_W      = 8,
  parameter int F_W       = 9,
  parameter int CHAR_PIX  = 8,
  parameter int ACT_CHARS = 40,
  parameter int VS_LINES  = 3,
  parameter int RST_LEN   = int'(DEF_LINE_LEN),
  parameter int RST_MG    = int'(DEF_MARGIN),
  parameter int RST_RISE  = int'(DEF_RISE),
  parameter int RST_FALL  = int'(DEF_FALL),
  parameter int RST_F     = int'(DEF_FRAME),
  localparam int PIX_W    = L_W + $clog2(CHAR_PIX),
  localparam int LN_W     = F_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [L_W-1:0]   cfg_line_len,
  input  logic [MG_W-1:0]  cfg_margin,
  input  logic [SE_W-1:0]  cfg_sync_rise,
  input  logic [SE_W-1:0]  cfg_sync_fall,
  input  logic [F_W-1:0]   cfg_frame_lines,
  input  logic             cfg_interlace,
  input  logic             cfg_composite,
  output logic [PIX_W-1:0] pix_x,
  output logic [LN_W-1:0]  line_cnt,
  output logic             active,
  output logic             margin,
  output logic             hsync,
  output logic             vsync,
  output logic             sync_out,
  output logic             field_odd
);

  logic [PIX_W-1:0] hpos;
  logic             line_end, hs_level, hs_positive, second_half, comp_mode;
  seg_e             seg;
  logic [LN_W-1:0]  vline;
  logic             fld, vs_act, sync_pin;

  crt_raster_hcount #(
    .L_W(L_W), .MG_W(MG_W), .SE_W(SE_W), .CHAR_PIX(CHAR_PIX),
    .ACT_CHARS(ACT_CHARS), .PIX_W(PIX_W), .RST_LEN(RST_LEN),
    .RST_MG(RST_MG), .RST_RISE(RST_RISE), .RST_FALL(RST_FALL)
  ) u_h (
    .clk(clk), .rst(rst),
    .cfg_len(cfg_line_len), .cfg_margin(cfg_margin),
    .cfg_rise(cfg_sync_rise), .cfg_fall(cfg_sync_fall),
    .cfg_comp(cfg_composite),
    .hpos(hpos), .line_end(line_end), .seg(seg),
    .hs_level(hs_level), .hs_positive(hs_positive),
    .second_half(second_half), .comp_mode(comp_mode)
  );

  crt_raster_vcount #(.F_W(F_W), .LN_W(LN_W), .RST_F(RST_F)) u_v (
    .clk(clk), .rst(rst), .line_end(line_end),
    .cfg_frame(cfg_frame_lines), .cfg_interlace(cfg_interlace),
    .vline(vline), .field_odd(fld)
  );

  crt_raster_sync #(.LN_W(LN_W), .VS_LINES(VS_LINES)) u_s (
    .vline(vline), .field_odd(fld), .second_half(second_half),
    .hs_level(hs_level), .hs_positive(hs_positive), .comp_mode(comp_mode),
    .vs_act(vs_act), .sync_pin(sync_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x     <= '0;
      line_cnt  <= '0;
      active    <= 1'b0;
      margin    <= 1'b0;
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      sync_out  <= 1'b0;
      field_odd <= 1'b0;
    end else begin
      pix_x     <= hpos;
      line_cnt  <= vline;
      active    <= (seg == SEG_ACTIVE);
      margin    <= (seg == SEG_LEFT) || (seg == SEG_RIGHT);
      hsync     <= hs_level;
      vsync     <= vs_act;
      sync_out  <= sync_pin;
      field_odd <= fld;
    end
  end

endmodule

// File: rtl/crt_raster_chk.sv
module crt_raster_chk #(
  parameter int PIX_W    = 9,
  parameter int LN_W     = 10,
  parameter int CHAR_PIX = 8,
  parameter int VS_LINES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] pix_x,
  input logic [LN_W-1:0]  line_cnt,
  input logic             active,
  input logic             margin,
  input logic             vsync,
  input logic             field_odd
);

  AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_x != '0) |=> ((pix_x == PIX_W'($past(pix_x) + PIX_W'(1))) || (pix_x == '0))); // R1

  AST_SEG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(active && margin)); // R2

  AST_ACT_LATE: assert property (@(posedge clk) disable iff (rst)
    active |-> (pix_x >= PIX_W'(2 * CHAR_PIX))); // R2

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pix_x != '0) |-> $stable(line_cnt)); // R4

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    ((pix_x == '0) && (line_cnt != '0)) |-> (line_cnt == LN_W'($past(line_cnt) + LN_W'(1)))); // R4

  AST_VS_EARLY: assert property (@(posedge clk) disable iff (rst)
    (vsync && !field_odd) |-> (line_cnt < LN_W'(VS_LINES))); // R5

  AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> ((pix_x == '0) && (line_cnt == '0))); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!active && !margin && !vsync && (pix_x == '0))); // R8

endmodule

bind crt_raster_gen crt_raster_chk #(
  .PIX_W(PIX_W), .LN_W(LN_W), .CHAR_PIX(CHAR_PIX), .VS_LINES(VS_LINES)
) u_chk (
  .clk(clk), .rst(rst), .pix_x(pix_x), .line_cnt(line_cnt),
  .active(active), .margin(margin), .vsync(vsync), .field_odd(field_odd)
);

// File: tb/crt_raster_gen_test.sv
module crt_raster_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_line_len    = 6'd63;
  logic [2:0] cfg_margin      = 3'd3;
  logic [7:0] cfg_sync_rise   = 8'd230;
  logic [7:0] cfg_sync_fall   = 8'd220;
  logic [8:0] cfg_frame_lines = 9'd310;
  logic       cfg_interlace   = 1'b0;
  logic       cfg_composite   = 1'b0;

  logic [8:0] pix_x;
  logic [9:0] line_cnt;
  logic active, margin, hsync, vsync, sync_out, field_odd;

  always #10 clk = ~clk;

  crt_raster_gen uut (
    .clk(clk), .rst(rst),
    .cfg_line_len(cfg_line_len), .cfg_margin(cfg_margin),
    .cfg_sync_rise(cfg_sync_rise), .cfg_sync_fall(cfg_sync_fall),
    .cfg_frame_lines(cfg_frame_lines), .cfg_interlace(cfg_interlace),
    .cfg_composite(cfg_composite),
    .pix_x(pix_x), .line_cnt(line_cnt), .active(active), .margin(margin),
    .hsync(hsync), .vsync(vsync), .sync_out(sync_out), .field_odd(field_odd)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model of the working settings and the position shown on the outputs
  int m_l = 63, m_mg = 3, m_su = 230, m_sd = 220, m_comp = 0;
  int m_f = 310, m_field = 0, mx = 0, my = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d line=%0d)", tag, act, exp, mx, my);
    end
  endtask

  task automatic check_all();
    int hl, mw, a0, a1, r1, rise, fall;
    bit pos, lvl, half, vs, hact, cs, pin, e_act, e_mar;
    hl    = (m_l + 1) * 8;
    mw    = (m_mg + 1) * 8;
    a0    = 8 + mw;
    a1    = a0 + 320;
    r1    = a1 + mw;
    e_act = (mx >= a0) && (mx < a1);
    e_mar = ((mx >= 8) && (mx < a0)) || ((mx >= a1) && (mx < r1));
    rise  = (m_su + 1) * 2;
    fall  = (m_sd + 1) * 2;
    pos   = (m_su < m_sd);
    lvl   = pos ? ((mx >= rise) && (mx < fall)) : !((mx >= fall) && (mx < rise));
    half  = (mx >= hl / 2);
    vs    = m_field ? (((my == 0) && half) || ((my >= 1) && (my < 3)) || ((my == 3) && !half))
                    : (my < 3);
    hact  = pos ? lvl : !lvl;
    cs    = hact ^ vs;
    pin   = m_comp ? (pos ? cs : !cs) : lvl;
    chk("R1 pix_x", int'(pix_x), mx);
    chk("R4 R9 line_cnt", int'(line_cnt), my);
    chk("R2 active", int'(active), int'(e_act));
    chk("R2 margin", int'(margin), int'(e_mar));
    chk("R3 hsync", int'(hsync), int'(lvl));
    if (m_field != 0) chk("R7 vsync odd field", int'(vsync), int'(vs));
    else              chk("R5 vsync", int'(vsync), int'(vs));
    if (m_comp != 0)  chk("R6 composite sync_out", int'(sync_out), int'(pin));
    else              chk("R3 sync_out horizontal", int'(sync_out), int'(pin));
    chk("R7 field_odd", int'(field_odd), m_field);
  endtask

  task automatic advance();
    if (mx == (m_l + 1) * 8 - 1) begin
      mx     = 0;
      m_l    = int'(cfg_line_len);
      m_mg   = int'(cfg_margin);
      m_su   = int'(cfg_sync_rise);
      m_sd   = int'(cfg_sync_fall);
      m_comp = int'(cfg_composite);
      if (my == m_f + 1) begin
        my      = 0;
        m_field = cfg_interlace ? (1 - m_field) : 0;
        m_f     = int'(cfg_frame_lines);
      end else begin
        my++;
      end
    end else begin
      mx++;
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      check_all();
      advance();
    end
  endtask

  // returns the last line number the design showed before the frame wrapped
  task automatic run_frames(input int k, output int last_dut_line);
    last_dut_line = 0;
    repeat (k) begin
      run(1);
      last_dut_line = int'(line_cnt);
      while (!((mx == 0) && (my == 0))) begin
        run(1);
        last_dut_line = int'(line_cnt);
      end
    end
  endtask

  task automatic apply(input int l, input int mg, input int su, input int sd,
                       input int comp, input int ilc, input int f);
    run(1);
    while (mx != 10) run(1);
    cfg_line_len    = 6'(l);
    cfg_margin      = 3'(mg);
    cfg_sync_rise   = 8'(su);
    cfg_sync_fall   = 8'(sd);
    cfg_composite   = 1'(comp);
    cfg_interlace   = 1'(ilc);
    cfg_frame_lines = 9'(f);
  endtask

  initial begin
    int last;
    // R8: outputs held low while reset is high
    repeat (4) begin
      @(negedge clk);
      chk("R8 reset pix_x", int'(pix_x), 0);
      chk("R8 reset active", int'(active), 0);
      chk("R8 reset vsync", int'(vsync), 0);
      chk("R8 reset hsync", int'(hsync), 0);
      chk("R8 reset sync_out", int'(sync_out), 0);
    end
    rst = 1'b0;
    @(posedge clk);
    // R8: default geometry on the first line
    run(443);
    chk("R8 default x", int'(pix_x), 442);
    chk("R8 default sync low at 442", int'(hsync), 0);
    chk("R8 default active off past 360", int'(active), 0);
    run(20);
    chk("R8 default sync high at 462", int'(hsync), 1);
    run(100);
    chk("R8 default line length 512", int'(line_cnt), 1);

    // short lines during the long default frame; new frame length set mid-frame
    apply(15, 0, 3, 9, 0, 0, 4);
    run_frames(1, last);
    chk("R9 frame kept 312 lines", last, 311);

    apply(47, 0, 10, 30, 0, 0, 4);
    run_frames(2, last);
    chk("R4 frame of 6 lines", last, 5);
    apply(63, 3, 230, 220, 0, 0, 4);
    run_frames(2, last);
    apply(63, 7, 50, 60, 1, 0, 4);
    run_frames(2, last);
    apply(55, 2, 200, 100, 1, 0, 4);
    run_frames(2, last);
    apply(63, 1, 40, 70, 1, 1, 5);
    run_frames(2, last);
    chk("R4 frame of 7 lines", last, 6);
    apply(63, 1, 40, 70, 0, 1, 3);
    run_frames(3, last);
    chk("R4 frame of 5 lines", last, 4);

    // R8: reset again in the middle of a line
    run(37);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset pix_x", int'(pix_x), 0);
    chk("R8 reset line_cnt", int'(line_cnt), 0);
    chk("R8 reset field_odd", int'(field_odd), 0);
    chk("R8 reset margin", int'(margin), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule